// File: doc/BRIEF.md
# Serial master task and event control slice

This block sits between a simple word-addressed register bus and a serial bus master core. Software starts core actions by writing 1 to task addresses. Each such write turns into a one-cycle task strobe toward the core. Core activity comes back as single-cycle event pulses. The block captures each pulse in a sticky event flag that software can read and clear.

A six-bit interrupt mask is changed through two addresses, one that sets bits and one that clears them. It feeds a single interrupt line. Two hardware shortcuts let the byte-boundary event raise the suspend or the stop strobe without software involvement. Three sticky error causes are kept in a write-1-to-clear register. A four-bit enable field gates every task strobe, and only one code value turns the core on.

The bus is a single-cycle write strobe with a combinational read port. All addresses are byte addresses with the two low bits zero. Tasks sit at 0x00 + 4*t, event flags at 0x40 + 4*k, shortcuts at 0x80, mask-set at 0x84, mask-clear at 0x88, error causes at 0x8C and enable at 0x90. Unmapped addresses read 0 and ignore writes.

Top module: `sm_task_event_ctrl`

## Requirements
- R1: After reset every event flag, mask bit, shortcut bit, error cause and the enable field are 0. Every mapped address reads 0, `task_o` is 0, `irq` is 0 and `core_en` is 0.
- R2: A write with data bit 0 equal to 1 to task address 0x00 + 4*t makes `task_o[t]` high for exactly the one cycle after the write, provided the core is enabled. The task indices are t=0 start-receive, 1 start-transmit, 2 stop, 3 suspend and 4 resume. A task write with data bit 0 equal to 0 gives no strobe. Task addresses read 0.
- R3: An `ev_i[k]` pulse sets event flag k, read as bit 0 at 0x40 + 4*k. The event indices are k=0 stopped, 1 byte-received, 2 byte-sent, 3 error, 4 byte-boundary and 5 suspended. A write stores data bit 0 into the flag, so writing 0 clears it. A pulse in the same cycle as a write leaves the flag at 1.
- R4: Writing 1s to 0x84 sets the matching mask bits, and writing 1s to 0x88 clears them. Zero bits leave mask bits unchanged. Both addresses read the current six-bit mask in bits 5:0, and mask bit k belongs to event k.
- R5: `irq` is high exactly when some event flag k and mask bit k are both 1.
- R6: Shortcut bit 0 (at 0x80) sends a byte-boundary pulse `ev_i[4]` to the suspend strobe `task_o[3]`. Shortcut bit 1 sends it to the stop strobe `task_o[2]`. The strobe appears in the cycle after the pulse, even when software writes 0 to the byte-boundary flag in that same cycle. Only bits 1:0 are stored.
- R7: The error register at 0x8C holds overrun in bit 0, address NACK in bit 1 and data NACK in bit 2. Each bit is set by the matching `err_i` pulse and cleared by writing 1 to it. A pulse in the same cycle as a clear leaves the bit set.
- R8: The enable register at 0x90 stores data bits 3:0 and reads them back. `core_en` is 1 only while the stored value is 5.
- R9: No task strobe appears, either from software or from a shortcut, in the cycle after one where `core_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_i | input | 6 | Event pulses from the core |
| err_i | input | 3 | Error cause pulses from the core |
| task_o | output | 5 | Task strobes to the core |
| core_en | output | 1 | Core enable |
| irq | output | 1 | Interrupt request |

## Verification
The task path is exercised with several cases: 1 and 0 in data bit 0, every task index, and enable codes other than 5 including one with upper bits set. Together these separate a correct strobe from an unconditional or wrong-index strobe. Event and error registers see pulses alone, writes alone, and pulses that collide with clearing writes; this separates set priority from write priority. Shortcuts are tried one at a time, both together, colliding with a byte-boundary clear, and while disabled. The interrupt line is followed through mask set and clear with flags both present and absent.

// File: rtl/sm_task_event_ctrl.sv
module sm_task_event_ctrl #(
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int NTASK   = 5,
  parameter int NEV     = 6,
  parameter int NERR    = 3,
  parameter int ENW     = 4,
  parameter int EN_CODE = 5,
  parameter int EV_BB   = 4,
  parameter int T_STOP  = 2,
  parameter int T_SUSP  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NEV-1:0]  ev_i,
  input  logic [NERR-1:0] err_i,
  output logic [NTASK-1:0] task_o,
  output logic            core_en,
  output logic            irq
);
  localparam logic [1:0] G_TASK = 2'd0, G_EV = 2'd1, G_CFG = 2'd2;
  localparam logic [3:0] R_SH = 4'd0, R_MSET = 4'd1, R_MCLR = 4'd2, R_ERR = 4'd3, R_EN = 4'd4;

  logic [NEV-1:0]   ev_q, mask_q, wr_ev;
  logic [NERR-1:0]  err_q;
  logic [1:0]       sh_q;
  logic [ENW-1:0]   en_q;
  logic [NTASK-1:0] wr_task, sc_req;

  logic [1:0] grp;
  logic [3:0] word;
  logic       aligned;
  assign grp     = bus_addr[7:6];
  assign word    = bus_addr[5:2];
  assign aligned = (bus_addr[1:0] == 2'b00) && (AW == 8 || bus_addr[AW-1:8] == '0);

  logic wr_cfg_any;
  assign wr_cfg_any = bus_wr && aligned && grp == G_CFG;

  always_comb begin
    for (int t = 0; t < NTASK; t++)
      wr_task[t] = bus_wr && aligned && grp == G_TASK && word == t[3:0] && bus_wdata[0];
    for (int k = 0; k < NEV; k++)
      wr_ev[k] = bus_wr && aligned && grp == G_EV && word == k[3:0];
  end

  always_comb begin
    sc_req = '0;
    sc_req[T_SUSP] = ev_i[EV_BB] & sh_q[0];
    sc_req[T_STOP] = ev_i[EV_BB] & sh_q[1];
  end

  assign core_en = (en_q == ENW'(EN_CODE));
  assign irq     = |(ev_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q   <= '0;
      mask_q <= '0;
      err_q  <= '0;
      sh_q   <= '0;
      en_q   <= '0;
      task_o <= '0;
    end else begin
      task_o <= core_en ? (wr_task | sc_req) : '0;
      ev_q   <= (ev_q & ~wr_ev) | (wr_ev & {NEV{bus_wdata[0]}}) | ev_i;
      err_q  <= (err_q & ~((wr_cfg_any && word == R_ERR) ? bus_wdata[NERR-1:0] : '0)) | err_i;
      if (wr_cfg_any && word == R_MSET) mask_q <= mask_q | bus_wdata[NEV-1:0];
      if (wr_cfg_any && word == R_MCLR) mask_q <= mask_q & ~bus_wdata[NEV-1:0];
      if (wr_cfg_any && word == R_SH)   sh_q   <= bus_wdata[1:0];
      if (wr_cfg_any && word == R_EN)   en_q   <= bus_wdata[ENW-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned && grp == G_EV) begin
      for (int k = 0; k < NEV; k++)
        if (word == k[3:0]) bus_rdata[0] = ev_q[k];
    end else if (aligned && grp == G_CFG) begin
      case (word)
        R_SH:           bus_rdata[1:0]      = sh_q;
        R_MSET, R_MCLR: bus_rdata[NEV-1:0]  = mask_q;
        R_ERR:          bus_rdata[NERR-1:0] = err_q;
        R_EN:           bus_rdata[ENW-1:0]  = en_q;
        default:        bus_rdata = '0;
      endcase
    end
  end

  a_r9_disabled_no_task: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> task_o == '0);

  a_r3_event_captured: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i != '0 |=> (ev_q & $past(ev_i)) == $past(ev_i));

  a_r5_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_q != '0);

  a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg_any && word == R_ERR) |=> (err_q & $past(bus_wdata[NERR-1:0] & ~err_i)) == '0);

  a_r6_bb_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i[EV_BB] && sh_q[1] && core_en) |=> task_o[T_STOP]);
endmodule

// File: tb/sm_task_event_ctrl_tb.sv
module sm_task_event_ctrl_tb;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [5:0]  ev_i = 0;
  logic [2:0]  err_i = 0;
  logic [4:0]  task_o;
  logic        core_en, irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sm_task_event_ctrl u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_i(ev_i), .err_i(err_i),
    .task_o(task_o), .core_en(core_en), .irq(irq));

  // behavioural reference state
  bit [5:0] m_ev, m_mask;
  bit [2:0] m_err;
  bit [1:0] m_sh;
  bit [3:0] m_en;
  bit [4:0] m_task;

  function automatic bit [31:0] ref_read(input bit [7:0] a);
    if (a >= 8'h40 && a <= 8'h54 && a[1:0] == 0) return {31'd0, m_ev[(a - 8'h40) >> 2]};
    case (a)
      8'h80: return {30'd0, m_sh};
      8'h84, 8'h88: return {26'd0, m_mask};
      8'h8C: return {29'd0, m_err};
      8'h90: return {28'd0, m_en};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input bit [7:0] a);
    if (a < 8'h40) return "R2";
    if (a < 8'h80) return "R3";
    case (a)
      8'h80: return "R6";
      8'h84, 8'h88: return "R4";
      8'h8C: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit wr, input bit [7:0] a, input bit [31:0] d,
                      input bit [5:0] ev, input bit [2:0] er, input string rtag = "");
    bit [4:0] nt;
    bit [5:0] nev;
    bus_wr = wr; bus_addr = a; bus_wdata = d; ev_i = ev; err_i = er;
    #1;
    check(bus_rdata == ref_read(a), rtag == "" ? tag_of(a) : rtag, bus_rdata, ref_read(a));
    check(task_o == m_task, "R2 R6 R9 task_o", task_o, m_task);
    check(irq == |(m_ev & m_mask), "R5 irq", irq, |(m_ev & m_mask));
    check(core_en == (m_en == 4'd5), "R8 core_en", core_en, m_en == 4'd5);
    nt = 0;
    if (wr && a < 8'h14 && a[1:0] == 0 && d[0]) nt[a >> 2] = 1;
    if (ev[4] && m_sh[0]) nt[3] = 1;
    if (ev[4] && m_sh[1]) nt[2] = 1;
    if (m_en != 4'd5) nt = 0;
    nev = m_ev;
    if (wr && a >= 8'h40 && a <= 8'h54 && a[1:0] == 0) nev[(a - 8'h40) >> 2] = d[0];
    nev |= ev;
    @(posedge clk);
    m_task = nt;
    m_ev = nev;
    if (wr) case (a)
      8'h80: m_sh = d[1:0];
      8'h84: m_mask |= d[5:0];
      8'h88: m_mask &= ~d[5:0];
      8'h8C: m_err &= ~d[2:0];
      8'h90: m_en = d[3:0];
      default: ;
    endcase
    m_err |= er;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state at every mapped address
    for (int a = 0; a < 8'h94; a += 4) step(0, 8'(a), 0, 0, 0, "R1 reset read");
    // R9: tasks while disabled
    step(1, 8'h08, 1, 0, 0);
    step(0, 8'h08, 0, 0, 0);
    // R8: enable codes
    step(1, 8'h90, 3, 0, 0);
    step(1, 8'h90, 32'h15, 0, 0);
    step(1, 8'h90, 4, 0, 0);
    step(1, 8'h04, 1, 0, 0);
    step(1, 8'h90, 5, 0, 0);
    step(0, 8'h90, 0, 0, 0);
    // R2: each task, data bit 0 = 1 and = 0
    for (int t = 0; t < 5; t++) begin
      step(1, 8'(4 * t), 1, 0, 0);
      step(1, 8'(4 * t), 2, 0, 0);
      step(0, 8'(4 * t), 0, 0, 0);
    end
    // R3: event capture, clear, collision
    step(0, 8'h44, 0, 6'b000010, 0);
    step(0, 8'h44, 0, 0, 0);
    step(1, 8'h44, 0, 0, 0);
    step(0, 8'h44, 0, 0, 0);
    step(1, 8'h4C, 0, 6'b001000, 0);
    step(0, 8'h4C, 0, 0, 0);
    step(0, 8'h54, 0, 6'b100001, 0);
    step(0, 8'h40, 0, 0, 0);
    // R4/R5: mask and interrupt
    step(1, 8'h84, 32'h02, 0, 0);
    step(0, 8'h88, 0, 0, 0);
    step(1, 8'h84, 32'h21, 0, 0);
    step(1, 8'h88, 32'h20, 0, 0);
    step(1, 8'h54, 0, 0, 0);
    step(1, 8'h40, 0, 0, 0);
    step(0, 8'h84, 0, 0, 0);
    step(0, 8'h44, 0, 6'b000010, 0);
    step(0, 8'h84, 0, 0, 0);
    // R6: shortcuts
    step(1, 8'h80, 32'hFF, 0, 0);
    step(1, 8'h80, 32'h1, 6'b010000, 0);
    step(1, 8'h80, 32'h2, 6'b010000, 0);
    step(1, 8'h50, 0, 6'b010000, 0);
    step(0, 8'h50, 0, 0, 0);
    step(1, 8'h80, 32'h3, 0, 0);
    step(0, 8'h80, 0, 6'b010000, 0);
    step(0, 8'h80, 0, 0, 0);
    // R9: shortcut while disabled
    step(1, 8'h90, 0, 0, 0);
    step(0, 8'h90, 0, 6'b010000, 0);
    step(1, 8'h0C, 1, 0, 0);
    step(0, 8'h00, 0, 0, 0);
    // R7: error causes
    step(0, 8'h8C, 0, 0, 3'b101);
    step(0, 8'h8C, 0, 0, 3'b010);
    step(1, 8'h8C, 32'h1, 0, 0);
    step(1, 8'h8C, 32'h6, 0, 3'b100);
    step(0, 8'h8C, 0, 0, 0);
    step(1, 8'h8C, 32'h7, 0, 0);
    step(0, 8'h8C, 0, 0, 0);
    step(0, 8'hA0, 0, 0, 0);
    summary();
  end
endmodule